// File: doc/BRIEF.md
# Frame-Synchronous Parallel Descrambler

This block removes (or applies) the line scrambling on a stream that already arrives aligned to frame boundaries, one 48-bit word per clock. Each accepted word is combined by XOR with the next 48 bits of a pseudo-random sequence. A 16-bit LFSR with feedback polynomial 1 + x + x^3 + x^12 + x^16 produces that sequence. The LFSR is unrolled in combinational logic, so it yields a full word of sequence bits every cycle without any stored table.

The generator restarts at every frame. The word flagged as start of frame holds the six alignment bytes, and it passes through untouched. The generator is reloaded with all ones so that its first bit lands on the first bit after those bytes. Because XOR with the same sequence is its own inverse, one instance serves on the transmit side as a scrambler and on the receive side as a descrambler. It sits between the frame aligner and the overhead/payload demultiplexer.

Top module: `frame_descrambler`

## Requirements
- R1: While rstN is low, and in the first cycle after it rises, validOut is 0 and dataOut is all zeros.
- R2: The sequence bits s[n] obey s[n+16] = s[n] ^ s[n+4] ^ s[n+13] ^ s[n+15], with s[0..15] all ones. Each word takes 48 consecutive bits, and the earliest bit goes to dataOut bit 47.
- R3: A word accepted with validIn=1 and sofIn=1 leaves on dataOut unchanged, because its 48 bits are the six alignment bytes.
- R4: The first valid word after a start-of-frame word uses sequence bits 0..47 (word 0xFFFF4E9105D2). An input of all ones therefore gives 0x0000B16EFA2D. This restart happens at every start-of-frame word, wherever the sequence stood.
- R5: Latency is one clock. validOut in cycle t+1 equals validIn in cycle t, and dataOut carries the result of the word accepted in cycle t.
- R6: While validIn is 0 the sequence does not advance and dataOut holds its last value. The next valid word continues exactly where the sequence stopped.
- R7: sofIn is ignored while validIn is 0. It causes no restart and no pass-through.
- R8: Feeding a frame's output back through the block as a new frame returns the original words.
- R9: After reset the generator stands at sequence bit 0. Valid words that arrive before any start-of-frame word are combined with the sequence from its beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Input word qualifier |
| sofIn | input | 1 | Marks the alignment word that starts a frame |
| dataIn | input | 48 | Aligned input word |
| validOut | output | 1 | Output word qualifier, one cycle after validIn |
| dataOut | output | 48 | Scrambled or descrambled word |

## Verification
Any corruption of the 16-bit generator state shows up in dataOut of the very next valid word as a wrong keystream. It then persists for every following word until the next start-of-frame word reloads the seed. A generator that advances during gaps, or that misses a restart, is therefore seen within one valid word after the event. The stimulus places gaps, ignored start markers and mid-frame restarts so that each of these faults changes a compared word.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  localparam int LFSR_W = 16;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;     // accept dataIn this cycle
    logic restart;  // accepted word is the alignment word
  } strobeT;

  // One serial step: oldest bit at the MSB, feedback enters at the LSB.
  function automatic logic [LFSR_W-1:0] lfsrStep(input logic [LFSR_W-1:0] s,
                                                 input logic [LFSR_W-1:0] taps);
    return {s[LFSR_W-2:0], ^(s & taps)};
  endfunction

endpackage

// File: rtl/fsd_ctrl.sv
module fsd_ctrl
  import fsd_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   validIn,
  input  logic   sofIn,
  output strobeT strobe,
  output logic   validOut
);

  always_comb begin
    strobe.load    = validIn;
    strobe.restart = validIn & sofIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

  // R5: output qualifier trails the input qualifier by exactly one clock
  p_valid_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> validOut == $past(validIn));

endmodule

// File: rtl/fsd_datapath.sv
module fsd_datapath
  import fsd_pkg::*;
#(
  parameter int                DATA_W = 48,
  parameter int                FAS_W  = 48,
  parameter logic [LFSR_W-1:0] SEED   = '1,
  parameter logic [LFSR_W-1:0] TAPS   = 16'h8805
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);

  localparam int REM_W = DATA_W - FAS_W;

  // DATA_W sequence bits, earliest bit at the word MSB.
  function automatic logic [DATA_W-1:0] seqWord(input logic [LFSR_W-1:0] s0);
    logic [DATA_W-1:0] w;
    logic [LFSR_W-1:0] s;
    s = s0;
    for (int i = 0; i < DATA_W; i++) begin
      w[DATA_W-1-i] = s[LFSR_W-1];
      s = lfsrStep(s, TAPS);
    end
    return w;
  endfunction

  // Advance the state by n steps, n no larger than DATA_W.
  function automatic logic [LFSR_W-1:0] advance(input logic [LFSR_W-1:0] s0,
                                                input int n);
    logic [LFSR_W-1:0] s;
    s = s0;
    for (int i = 0; i < DATA_W; i++)
      if (i < n) s = lfsrStep(s, TAPS);
    return s;
  endfunction

  logic [LFSR_W-1:0] lfsrQ, lfsrD;
  logic [DATA_W-1:0] keyStream, restartKs;
  logic [LFSR_W-1:0] restartNext;

  // Restart variant: alignment field fills the word, or leaves a tail.
  generate
    if (REM_W == 0) begin : g_full_fas
      assign restartKs   = '0;
      assign restartNext = SEED;
    end else begin : g_part_fas
      assign restartKs   = seqWord(SEED) >> FAS_W;
      assign restartNext = advance(SEED, REM_W);
    end
  endgenerate

  always_comb begin
    if (strobe.restart) begin
      keyStream = restartKs;
      lfsrD     = restartNext;
    end else if (strobe.load) begin
      keyStream = seqWord(lfsrQ);
      lfsrD     = advance(lfsrQ, DATA_W);
    end else begin
      keyStream = '0;
      lfsrD     = lfsrQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ   <= SEED;
      dataOut <= '0;
    end else begin
      lfsrQ <= lfsrD;
      if (strobe.load) dataOut <= dataIn ^ keyStream;
    end
  end

  // R2: a maximal-length generator never reaches the all-zero lock-up state
  p_lfsr_live_r2: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

  // R6: no valid word, no change of state or output
  p_gap_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(lfsrQ) && $stable(dataOut));

  // R3: alignment field leaves the block exactly as it came in
  p_fas_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> dataOut[DATA_W-1 -: FAS_W] == $past(dataIn[DATA_W-1 -: FAS_W]));

endmodule

// File: rtl/frame_descrambler.sv
module frame_descrambler
  import fsd_pkg::*;
#(
  parameter int                DATA_W    = 48,
  parameter int                FAS_BYTES = 6,
  parameter logic [LFSR_W-1:0] SEED      = 16'hFFFF,
  parameter logic [LFSR_W-1:0] TAPS      = 16'h8805
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic              sofIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              validOut,
  output logic [DATA_W-1:0] dataOut
);

  localparam int FAS_W = FAS_BYTES * 8;

  strobeT strobe;

  fsd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .sofIn    (sofIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  fsd_datapath #(
    .DATA_W (DATA_W),
    .FAS_W  (FAS_W),
    .SEED   (SEED),
    .TAPS   (TAPS)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: tb/frame_descrambler_bench.sv
module frame_descrambler_bench;

  localparam int W     = 48;
  localparam int SEQ_N = W * 64;
  localparam int NSTIM = 18;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         validIn = 1'b0;
  logic         sofIn = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic         validOut;
  logic [W-1:0] dataOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  frame_descrambler u_frame_descrambler (
    .clk(clk), .rstN(rstN), .validIn(validIn), .sofIn(sofIn),
    .dataIn(dataIn), .validOut(validOut), .dataOut(dataOut)
  );

  // Reference sequence from the recurrence of R2.
  logic seqBits [0:SEQ_N-1];
  initial begin
    for (int n = 0; n < SEQ_N; n++)
      seqBits[n] = (n < 16) ? 1'b1
                 : seqBits[n-16] ^ seqBits[n-12] ^ seqBits[n-3] ^ seqBits[n-1];
  end

  function automatic logic [W-1:0] seqAt(input int pos);
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[W-1-i] = seqBits[pos+i];
    return w;
  endfunction

  // {validIn, sofIn, dataIn}
  localparam logic [W+1:0] STIM [0:NSTIM-1] = '{
    {1'b1, 1'b0, 48'h000000000000},  // 0  before any sof, R9
    {1'b1, 1'b0, 48'hAAAAAAAAAAAA},  // 1
    {1'b0, 1'b1, 48'hDEADBEEF0000},  // 2  sof without valid, R7
    {1'b1, 1'b0, 48'h123456789ABC},  // 3  continues after ignored sof
    {1'b1, 1'b1, 48'hF6F6F6282828},  // 4  alignment word, R3
    {1'b1, 1'b0, 48'hFFFFFFFFFFFF},  // 5  R4 known value
    {1'b0, 1'b0, 48'h555555555555},  // 6  gap, R6
    {1'b0, 1'b0, 48'h0F0F0F0F0F0F},  // 7  gap, R6
    {1'b1, 1'b0, 48'h000000000000},  // 8  continues after gap
    {1'b1, 1'b0, 48'hFFFF00000000},  // 9
    {1'b1, 1'b1, 48'hF6F6F6282828},  // 10 restart mid-frame, R4
    {1'b1, 1'b0, 48'h000000000000},  // 11 seed word again
    {1'b1, 1'b0, 48'h800000000001},  // 12
    {1'b1, 1'b0, 48'h0123456789AB},  // 13
    {1'b0, 1'b0, 48'h000000000000},  // 14 gap
    {1'b1, 1'b0, 48'hCAFEF00D1234},  // 15
    {1'b1, 1'b0, 48'hFEDCBA987654},  // 16
    {1'b1, 1'b1, 48'h000000000000}   // 17 alignment word of zeros, R3
  };

  task automatic checkEq(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive away from the edge, sample 2 ns after the capturing edge.
  task automatic apply(input logic v, input logic s, input logic [W-1:0] d);
    @(negedge clk);
    validIn = v; sofIn = s; dataIn = d;
    @(posedge clk);
    #2;
  endtask

  logic [W-1:0] outLog [0:NSTIM-1];
  logic [W-1:0] orig [0:5];
  logic [W-1:0] scr  [0:5];

  initial begin : watchdog
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int pos;
    logic [W-1:0] expData;
    logic         v, s;
    logic [W-1:0] d;

    // R1: reset state
    #35;
    checkEq("R1 validOut in reset", {47'b0, validOut}, '0);
    checkEq("R1 dataOut in reset", dataOut, '0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
    checkEq("R1 validOut after reset", {47'b0, validOut}, '0);
    checkEq("R1 dataOut after reset", dataOut, '0);

    // Table walk against the reference sequence model
    pos = 0;
    expData = '0;
    for (int i = 0; i < NSTIM; i++) begin
      {v, s, d} = STIM[i];
      apply(v, s, d);
      if (v && s) begin
        expData = d;
        pos = 0;
      end else if (v) begin
        expData = d ^ seqAt(pos);
        pos += W;
      end
      outLog[i] = dataOut;
      if (!v && s)      checkEq("R7 sof ignored without valid", dataOut, expData);
      else if (!v)      checkEq("R6 hold during gap", dataOut, expData);
      else if (s)       checkEq("R3 alignment word passes", dataOut, expData);
      else              checkEq("R2 sequence word", dataOut, expData);
      checkEq("R5 validOut follows validIn", {47'b0, validOut}, {47'b0, v});
    end

    // Fixed known values
    checkEq("R9 first word after reset uses seed", outLog[0], 48'hFFFF4E9105D2);
    checkEq("R4 all ones after alignment word", outLog[5], 48'h0000B16EFA2D);
    checkEq("R4 restart mid-frame", outLog[11], 48'hFFFF4E9105D2);
    checkEq("R6 sequence resumes after gap", outLog[8], seqAt(W));

    // R8: scrambling twice returns the original frame
    apply(1'b1, 1'b1, 48'hF6F6F6282828);
    for (int i = 0; i < 6; i++) begin
      orig[i] = 48'h0F1E2D3C4B5A * (i + 3) ^ 48'h5A5A00FF1234;
      apply(1'b1, 1'b0, orig[i]);
      scr[i] = dataOut;
    end
    apply(1'b1, 1'b1, 48'hF6F6F6282828);
    for (int i = 0; i < 6; i++) begin
      apply(1'b1, 1'b0, scr[i]);
      checkEq("R8 double pass restores data", dataOut, orig[i]);
    end

    // R1/R9: reset mid-stream reseeds the generator
    @(negedge clk);
    rstN = 1'b0;
    validIn = 1'b0; sofIn = 1'b0;
    #2;
    checkEq("R1 validOut on mid-run reset", {47'b0, validOut}, '0);
    checkEq("R1 dataOut on mid-run reset", dataOut, '0);
    @(negedge clk);
    rstN = 1'b1;
    apply(1'b1, 1'b0, 48'hFFFFFFFFFFFF);
    checkEq("R9 reseed after reset", dataOut, 48'h0000B16EFA2D);
    apply(1'b1, 1'b0, 48'h000000000000);
    checkEq("R9 second word after reset", dataOut, seqAt(W));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule